// File: doc/BRIEF.md
# Indirect-Access Command Mailbox

This block is a command mailbox that a host reaches through two registers: an index register and a data register. The host first writes an internal address into the index register. A read or write of the data register then reaches the mailbox register at that address. Behind the pair sit three kinds of register: a command-ID register, a status register, and a bank of argument words.

To issue a command, the host takes these steps in order:
1. Clear the status register.
2. Load the argument words.
3. Write the command ID, which starts the command.

A built-in engine services pending commands only on a periodic service tick, so the completion latency depends on where the trigger falls relative to that tick. At the tick the engine checks the ID and computes the result. It writes any result word back over argument word 0 and posts a status code. Until that point the status reads as not-ready.

Only a test command (argument plus one) and a small table of valid and reserved IDs are modelled.

Top module: `cmd_mailbox`

## Requirements
- R1: A host read at offset 0xC4 returns the last value written to offset 0xC4. After reset this value is 0.
- R2: A host access at offset 0xC8 reaches the internal register whose address is held at 0xC4. Internal addresses are 0x3B10534 (command ID), 0x3B10980 (status, in bits 7:0) and 0x3B109E0 + 4·n (argument word n, for n from 0 to 7).
- R3: A data-register read of any other internal address returns 0, and a write to such an address changes nothing. A host read at an offset other than 0xC4 or 0xC8 returns 0.
- R4: An accepted command-ID write sets the status to 0x00 (not ready). The status reads 0x00 on every cycle until the command completes.
- R5: Service ticks fall on clock edges k = P, 2P, 3P and so on, counted from reset release, where P is the service period (64 in the bench). A command triggered at edge k_w completes at the first tick edge after k_w.
- R6: Command ID 1 (test) writes argument word 0 plus 1 into argument word 0 and posts status 0x01. 0xDEADBEEF becomes 0xDEADBEF0, and the other argument words are unchanged.
- R7: With the argument check enabled, a test command whose argument word 0 is 0xFFFFFFFF posts status 0xFF and leaves the argument words unchanged.
- R8: Command ID 0, any ID of 8 or more, and the reserved ID 4 all post status 0xFE and leave the argument words unchanged.
- R9: The remaining valid IDs (2, 3, 5, 6, 7) post status 0x01 and leave the argument words unchanged.
- R10: A command-ID write while a command is pending is ignored. The ID register keeps its value and the completion edge does not move.
- R11: After reset the index, command ID, status and all argument words read 0.
- R12: The host can write the status register directly, and the written low byte reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read enable; read data is combinational |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data; 0 when host_rd is low |

## Verification
Register reads are combinational and take effect with no clock edge. Host writes take effect at the rising edge where the strobe is high. The bench therefore samples reads shortly after a falling edge and checks each write at the next falling edge.

A command's result is due exactly at the first multiple of the service period after the trigger edge. The bench keeps its own count of edges since reset release and computes that edge from the trigger edge. With the index pointed at the status register, it polls the status every cycle. Status must be 0x00 before that edge and the final code at it.

The pending-write test first aligns to a known tick phase. This guarantees that the second ID write lands while the first command is still waiting.

// File: rtl/cm_pkg.sv
package cm_pkg;
   typedef enum logic [7:0] {
      ST_BUSY   = 8'h00,
      ST_OK     = 8'h01,
      ST_BADMSG = 8'hFE,
      ST_BADIN  = 8'hFF
   } cm_stat_e;

   localparam int STAT_W = 8;
endpackage

// File: rtl/cm_tick.sv
module cm_tick #(
   parameter int PERIOD = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("cm_tick: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

   // R5
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/cm_decode.sv
module cm_decode #(
   parameter int          NARG     = 8,
   parameter int          AW       = 32,
   parameter logic [31:0] ID_ADR   = 32'h03B1_0534,
   parameter logic [31:0] ST_ADR   = 32'h03B1_0980,
   parameter logic [31:0] ARG_BASE = 32'h03B1_09E0
) (
   input  logic [AW-1:0]           addr,
   output logic                    hit_id,
   output logic                    hit_st,
   output logic [NARG-1:0]         hit_arg,
   output logic [$clog2(NARG)-1:0] arg_idx
);
   localparam int SW = $clog2(NARG);

   generate
      if (ID_ADR == ST_ADR) begin : g_clash
         $error("cm_decode: ID and status addresses coincide");
      end
      if (NARG < 2) begin : g_narg
         $error("cm_decode: NARG must be at least 2");
      end
   endgenerate

   assign hit_id = (addr == AW'(ID_ADR));
   assign hit_st = (addr == AW'(ST_ADR));

   for (genvar i = 0; i < NARG; i++) begin : g_arg
      assign hit_arg[i] = (addr == AW'(ARG_BASE + 32'(4 * i)));
   end

   always_comb begin
      arg_idx = '0;
      for (int i = 0; i < NARG; i++) begin
         if (hit_arg[i]) arg_idx = SW'(i);
      end
   end
endmodule

// File: rtl/cm_engine.sv
module cm_engine
   import cm_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          ID_LIMIT  = 8,
   parameter logic [31:0] RSVD_MASK = 32'h0000_0010,
   parameter int          TEST_ID   = 1,
   parameter bit          ARG_CHK   = 1'b1
) (
   input  logic [DW-1:0] cmd_id,
   input  logic [DW-1:0] arg0,
   output cm_stat_e      code,
   output logic          wr0,
   output logic [DW-1:0] res0
);
   logic id_ok;
   logic reject;

   generate
      if (ID_LIMIT > 32 || ID_LIMIT < 2) begin : g_lim
         $error("cm_engine: ID_LIMIT must be in 2..32");
      end
      if (ARG_CHK) begin : g_chk
         assign reject = (arg0 == {DW{1'b1}});
      end else begin : g_nochk
         assign reject = 1'b0;
      end
   endgenerate

   assign id_ok = (cmd_id != '0) && (cmd_id < DW'(ID_LIMIT))
                  && !RSVD_MASK[cmd_id[4:0]];
   assign res0  = arg0 + 1'b1;

   always_comb begin
      code = ST_OK;
      wr0  = 1'b0;
      if (!id_ok) begin
         code = ST_BADMSG;
      end else if (cmd_id == DW'(TEST_ID)) begin
         if (reject) code = ST_BADIN;
         else        wr0  = 1'b1;
      end
   end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import cm_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          HW        = 8,
   parameter int          NARG      = 8,
   parameter int          PERIOD    = 64,
   parameter logic [7:0]  IDX_OFS   = 8'hC4,
   parameter logic [7:0]  DAT_OFS   = 8'hC8,
   parameter logic [31:0] ID_ADR    = 32'h03B1_0534,
   parameter logic [31:0] ST_ADR    = 32'h03B1_0980,
   parameter logic [31:0] ARG_BASE  = 32'h03B1_09E0,
   parameter int          ID_LIMIT  = 8,
   parameter logic [31:0] RSVD_MASK = 32'h0000_0010,
   parameter int          TEST_ID   = 1,
   parameter bit          ARG_CHK   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [HW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata
);
   localparam int SW = $clog2(NARG);

   generate
      if (DW < STAT_W) begin : g_dw
         $error("cmd_mailbox: DW must hold a status byte");
      end
      if (IDX_OFS == DAT_OFS) begin : g_ofs
         $error("cmd_mailbox: index and data offsets coincide");
      end
   endgenerate

   logic [DW-1:0]     idx_q, id_q;
   logic [STAT_W-1:0] stat_q;
   logic [DW-1:0]     arg_q [NARG];
   logic              pend_q;

   logic              tick, hit_id, hit_st;
   logic [NARG-1:0]   hit_arg;
   logic [SW-1:0]     arg_idx;
   cm_stat_e          eng_code;
   logic              eng_wr;
   logic [DW-1:0]     eng_res;

   logic wr_idx, wr_dat, trig, done;

   cm_tick #(.PERIOD(PERIOD)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   cm_decode #(
      .NARG(NARG), .AW(DW), .ID_ADR(ID_ADR), .ST_ADR(ST_ADR), .ARG_BASE(ARG_BASE)
   ) u_dec (
      .addr(idx_q), .hit_id(hit_id), .hit_st(hit_st),
      .hit_arg(hit_arg), .arg_idx(arg_idx)
   );

   cm_engine #(
      .DW(DW), .ID_LIMIT(ID_LIMIT), .RSVD_MASK(RSVD_MASK),
      .TEST_ID(TEST_ID), .ARG_CHK(ARG_CHK)
   ) u_eng (
      .cmd_id(id_q), .arg0(arg_q[0]), .code(eng_code), .wr0(eng_wr), .res0(eng_res)
   );

   assign wr_idx = host_wr && (host_addr == HW'(IDX_OFS));
   assign wr_dat = host_wr && (host_addr == HW'(DAT_OFS));
   assign trig   = wr_dat && hit_id && !pend_q;
   assign done   = pend_q && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         id_q   <= '0;
         pend_q <= 1'b0;
         stat_q <= ST_BUSY;
      end else begin
         if (wr_idx) idx_q <= host_wdata;
         if (trig)   id_q  <= host_wdata;
         if (done)      pend_q <= 1'b0;
         else if (trig) pend_q <= 1'b1;
         if (done)                 stat_q <= eng_code;
         else if (trig)            stat_q <= ST_BUSY;
         else if (wr_dat && hit_st) stat_q <= host_wdata[STAT_W-1:0];
      end
   end

   for (genvar i = 0; i < NARG; i++) begin : g_args
      if (i == 0) begin : g_w0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      arg_q[i] <= '0;
            else if (done && eng_wr)         arg_q[i] <= eng_res;
            else if (wr_dat && hit_arg[i])   arg_q[i] <= host_wdata;
         end
      end else begin : g_wn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    arg_q[i] <= '0;
            else if (wr_dat && hit_arg[i]) arg_q[i] <= host_wdata;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (host_addr == HW'(IDX_OFS)) begin
            host_rdata = idx_q;
         end else if (host_addr == HW'(DAT_OFS)) begin
            if (hit_id)          host_rdata = id_q;
            else if (hit_st)     host_rdata = DW'(stat_q);
            else if (|hit_arg)   host_rdata = arg_q[arg_idx];
         end
      end
   end

   // R4
   trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> (stat_q == ST_BUSY));

   // R10
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> $stable(id_q));

   // R5
   done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(tick));

   // R6
   test_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && tick && eng_wr) |=> (arg_q[0] == $past(arg_q[0]) + 1'b1) && (stat_q == ST_OK));

   // R8
   bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && tick && !eng_wr && !(wr_dat && hit_arg[0])) |=> $stable(arg_q[0]));
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          P     = 64;
   localparam logic [7:0]  IDX   = 8'hC4;
   localparam logic [7:0]  DAT   = 8'hC8;
   localparam logic [31:0] A_ID  = 32'h03B1_0534;
   localparam logic [31:0] A_ST  = 32'h03B1_0980;
   localparam logic [31:0] A_ARG = 32'h03B1_09E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int errors = 0;
   int checks = 0;
   int edge_n = 0;

   always #2 clk = ~clk;

   always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

   cmd_mailbox #(.PERIOD(P)) u_cmd_mailbox (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] ofs, input logic [31:0] d);
      host_wr = 1'b1; host_addr = ofs; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] ofs, output logic [31:0] d);
      host_rd = 1'b1; host_addr = ofs;
      #1;
      d = host_rdata;
      host_rd = 1'b0;
   endtask

   task automatic mb_wr(input logic [31:0] a, input logic [31:0] d);
      hwrite(IDX, a);
      hwrite(DAT, d);
   endtask

   task automatic mb_rd(input logic [31:0] a, output logic [31:0] d);
      hwrite(IDX, a);
      hread(DAT, d);
   endtask

   // Waits for completion of a command triggered at edge kw; checks busy and final status.
   task automatic await_done(input string tag, input int kw, input logic [7:0] exp_st);
      int due;
      int busy_bad;
      logic [31:0] v;
      due = ((kw / P) + 1) * P;
      busy_bad = 0;
      hwrite(IDX, A_ST);
      for (int n = 0; n < P + 4; n++) begin
         hread(DAT, v);
         if (edge_n >= due) break;
         if (v != 32'h0) busy_bad++;
         @(negedge clk);
      end
      check({tag, " R4 busy reads"}, 32'(busy_bad), 32'd0);
      check({tag, " R5 done edge"}, 32'(edge_n), 32'(due));
      check({tag, " status"}, v, {24'h0, exp_st});
   endtask

   task automatic run_cmd(input string tag, input logic [31:0] id, input logic [7:0] exp_st);
      int kw;
      mb_wr(A_ST, 32'h0);
      mb_wr(A_ID, id);
      kw = edge_n;
      await_done(tag, kw, exp_st);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      hread(IDX, v); check("R11 index", v, 32'h0);
      hread(DAT, v); check("R11 data at addr 0", v, 32'h0);
      mb_rd(A_ST, v); check("R11 status", v, 32'h0);
      mb_rd(A_ID, v); check("R11 id", v, 32'h0);
      mb_rd(A_ARG + 32'd28, v); check("R11 arg7", v, 32'h0);
   endtask

   task automatic t_index;
      logic [31:0] v;
      hwrite(IDX, 32'h1234_5678);
      hread(IDX, v); check("R1 index readback", v, 32'h1234_5678);
   endtask

   task automatic t_args;
      logic [31:0] v;
      for (int i = 0; i < 8; i++) mb_wr(A_ARG + 32'(4 * i), 32'hA000_0000 + 32'(i));
      mb_rd(A_ARG + 32'd12, v); check("R2 arg3", v, 32'hA000_0003);
      mb_rd(A_ARG + 32'd28, v); check("R2 arg7", v, 32'hA000_0007);
      mb_rd(A_ARG, v);          check("R2 arg0", v, 32'hA000_0000);
      mb_wr(A_ST, 32'h0000_005A);
      mb_rd(A_ST, v);           check("R12 status write", v, 32'h0000_005A);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      mb_wr(A_ARG + 32'd2, 32'hFFFF_FFFF);
      mb_rd(A_ARG + 32'd2, v); check("R3 unaligned read", v, 32'h0);
      mb_rd(A_ARG, v);         check("R3 arg0 untouched", v, 32'hA000_0000);
      mb_rd(A_ARG + 32'd4, v); check("R3 arg1 untouched", v, 32'hA000_0001);
      mb_rd(A_ARG + 32'd32, v); check("R3 past last arg", v, 32'h0);
      hwrite(8'h10, 32'h5555_5555);
      hread(8'h10, v);         check("R3 unmapped offset", v, 32'h0);
   endtask

   task automatic t_test_cmd;
      logic [31:0] v;
      mb_wr(A_ARG, 32'hDEAD_BEEF);
      mb_wr(A_ARG + 32'd4, 32'h0000_0055);
      run_cmd("R6 test", 32'd1, 8'h01);
      mb_rd(A_ARG, v);         check("R6 result word", v, 32'hDEAD_BEF0);
      mb_rd(A_ARG + 32'd4, v); check("R6 arg1 kept", v, 32'h0000_0055);
   endtask

   task automatic t_bad_input;
      logic [31:0] v;
      mb_wr(A_ARG, 32'hFFFF_FFFF);
      run_cmd("R7 reject", 32'd1, 8'hFF);
      mb_rd(A_ARG, v); check("R7 arg0 kept", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_bad_msg;
      logic [31:0] v;
      mb_wr(A_ARG, 32'h0000_0100);
      run_cmd("R8 id0", 32'd0, 8'hFE);
      run_cmd("R8 id9", 32'd9, 8'hFE);
      run_cmd("R8 id4 reserved", 32'd4, 8'hFE);
      mb_rd(A_ARG, v); check("R8 arg0 kept", v, 32'h0000_0100);
   endtask

   task automatic t_other_ids;
      logic [31:0] v;
      run_cmd("R9 id3", 32'd3, 8'h01);
      run_cmd("R9 id7", 32'd7, 8'h01);
      mb_rd(A_ARG, v); check("R9 arg0 kept", v, 32'h0000_0100);
   endtask

   task automatic t_pending_write;
      logic [31:0] v;
      int kw;
      mb_wr(A_ARG, 32'h0000_0005);
      mb_wr(A_ST, 32'h0);
      while ((edge_n % P) != 3) @(negedge clk);
      mb_wr(A_ID, 32'd1);
      kw = edge_n;
      hwrite(DAT, 32'd0);
      hread(DAT, v); check("R10 id kept", v, 32'd1);
      await_done("R10 pending", kw, 8'h01);
      mb_rd(A_ARG, v); check("R10 result", v, 32'h0000_0006);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_args();
      t_unmapped();
      t_test_cmd();
      t_bad_input();
      t_bad_msg();
      t_other_ids();
      t_pending_write();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule